// File: doc/BRIEF.md
# Lane-Partitioned Wraparound SIMD Adder

This block adds two operand vectors as a set of independent integer lanes. A lane-size selector splits the full-width carry chain into 8-bit, 16-bit or 32-bit pieces while the block runs. The carry is cut at every lane edge, so each lane computes its sum modulo 2 to the power of its width. The same sum is correct for unsigned lanes and for two's-complement signed lanes. The block produces no carry, overflow or saturation indication.

A width select chooses between a 64-bit vector held in the low half of the operands and a 128-bit vector that uses the full width. With the 64-bit vector there are 8, 4 or 2 lanes, and the upper half of the result is forced to zero. With the 128-bit vector there are 16, 8 or 4 lanes. The result is registered and comes out one clock after the operands, together with a valid flag.

Top module: `simd_wrap_adder`

## Requirements
- R1: With `lane_sel` = 2'b00 (byte lanes), every 8-bit lane of `sum` equals the low 8 bits of the sum of the matching operand bytes. The carry out of the lane is dropped. The result is the same whether the lane holds signed or unsigned values, for example 8'hFF + 8'hFF = 8'hFE.
- R2: With `lane_sel` = 2'b01 (word lanes), every 16-bit lane of `sum` holds the low 16 bits of the lane sum.
- R3: With `lane_sel` = 2'b10 (doubleword lanes), every 32-bit lane of `sum` holds the low 32 bits of the lane sum.
- R4: `lane_sel` = 2'b11 gives exactly the same result as 2'b10.
- R5: A carry out of a lane never reaches the next lane. With all-ones operands, every lane reads all-ones except for a 0 in its least significant bit.
- R6: With `wide` = 0 the vector is the low 64 bits and holds 8, 4 or 2 lanes. Bits 127:64 of `sum` are zero, whatever the upper operand bits are.
- R7: With `wide` = 1 the vector is all 128 bits and holds 16, 8 or 4 lanes.
- R8: `sum` and `out_valid` change on the clock edge that samples `in_valid` = 1. `out_valid` then reads 1. After an edge that samples `in_valid` = 0, `out_valid` reads 0 and `sum` keeps its previous value.
- R9: While `rst_n` is low, `out_valid` and `sum` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are valid this cycle |
| wide | input | 1 | 1: 128-bit vector, 0: 64-bit vector in the low half |
| lane_sel | input | 2 | 00 byte, 01 word, 10 or 11 doubleword lanes |
| opa | input | 128 | First operand vector |
| opb | input | 128 | Second operand vector |
| out_valid | output | 1 | `sum` holds a new result |
| sum | output | 128 | Registered lane-wise wraparound sum |

## Verification
The hardest case to reach is a carry that tries to leave its lane. Random operands seldom produce carries at every lane edge at the same time. The stimulus therefore uses all-ones operands, and all-ones plus one in each lane, in every lane size and both widths. This places a carry at every boundary, and any leak shows up as a changed bit in the neighbouring lane. The 64-bit cases put nonzero data in the upper operand halves, so that a fault in the zeroing of the upper result also becomes visible.

// File: rtl/simd_wrap_adder.sv
module simd_wrap_adder #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             wide,
  input  logic [1:0]       lane_sel,
  input  logic [VEC_W-1:0] opa,
  input  logic [VEC_W-1:0] opb,
  output logic             out_valid,
  output logic [VEC_W-1:0] sum
);
  localparam int NBYTES = VEC_W / 8;
  localparam int HALF   = VEC_W / 2;

  logic [NBYTES-1:0] cy;
  logic [NBYTES-1:0] cut;
  logic [VEC_W-1:0]  raw;
  logic [VEC_W-1:0]  masked;

  assign cy[0] = 1'b0;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam bit AT_WORD = (i % 2) == 0;
    localparam bit AT_DW   = (i % 4) == 0;
    logic cin;
    assign cut[i] = (i == 0) || (lane_sel == 2'b00) ||
                    (lane_sel == 2'b01 && AT_WORD) ||
                    (lane_sel[1] && AT_DW);
    assign cin = cut[i] ? 1'b0 : cy[i];
    if (i < NBYTES - 1) begin : g_mid
      logic [8:0] s;
      assign s = {1'b0, opa[8*i +: 8]} + {1'b0, opb[8*i +: 8]} + {8'd0, cin};
      assign raw[8*i +: 8] = s[7:0];
      assign cy[i+1] = s[8];
    end else begin : g_last
      assign raw[8*i +: 8] = opa[8*i +: 8] + opb[8*i +: 8] + {7'd0, cin};
    end
  end

  assign masked = wide ? raw : {{HALF{1'b0}}, raw[HALF-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sum       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) sum <= masked;
    end
  end
endmodule

// File: rtl/simd_wrap_adder_chk.sv
module simd_wrap_adder_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             wide,
  input logic [1:0]       lane_sel,
  input logic [VEC_W-1:0] opa,
  input logic [VEC_W-1:0] opb,
  input logic             out_valid,
  input logic [VEC_W-1:0] sum
);
  // Lane 1 of each size is checked alone; it is also the lane that a leaked carry (R5) would corrupt
  assert_byte_lane_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && lane_sel == 2'b00 |=> sum[15:8] == 8'($past(opa[15:8]) + $past(opb[15:8])));

  assert_word_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && lane_sel == 2'b01 |=> sum[31:16] == 16'($past(opa[31:16]) + $past(opb[31:16])));

  assert_dword_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && lane_sel[1] |=> sum[63:32] == 32'($past(opa[63:32]) + $past(opb[63:32])));

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !wide |=> sum[VEC_W-1:VEC_W/2] == '0);

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(sum));
endmodule

bind simd_wrap_adder simd_wrap_adder_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide(wide), .lane_sel(lane_sel),
  .opa(opa), .opb(opb), .out_valid(out_valid), .sum(sum)
);

// File: tb/sim_simd_wrap_adder.sv
module sim_simd_wrap_adder;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         wide = 1'b0;
  logic [1:0]   lane_sel = 2'b00;
  logic [127:0] opa = '0;
  logic [127:0] opb = '0;
  logic         out_valid;
  logic [127:0] sum;
  int applied = 0;
  int errors  = 0;

  always #2 clk = ~clk;

  simd_wrap_adder u0 (.*);

  localparam int NV = 10;
  // {wide, lane_sel, opa, opb}
  localparam logic [258:0] VEC [NV] = '{
    {1'b1, 2'b00, 128'h80_7F_FF_01_10_20_30_40_50_60_70_80_90_A0_B0_C0, 128'h80_01_FF_FF_F0_E0_D0_C0_B0_A0_90_80_70_60_50_40},
    {1'b0, 2'b00, 128'hDEADBEEF_CAFEF00D_01234567_89ABCDEF, 128'h11111111_22222222_FEDCBA98_76543210},
    {1'b1, 2'b01, 128'h8000_7FFF_FFFF_0001_1234_ABCD_F000_0FFF, 128'h8000_0001_0001_FFFF_EDCB_5433_1000_F001},
    {1'b0, 2'b01, 128'hFFFFFFFF_FFFFFFFF_8001_7FFF_00FF_FF00, 128'hAAAAAAAA_55555555_8001_0001_FF01_0100},
    {1'b1, 2'b10, 128'h80000000_7FFFFFFF_FFFFFFFF_12345678, 128'h80000000_00000001_00000001_EDCBA988},
    {1'b0, 2'b10, 128'h0F0F0F0F_F0F0F0F0_C0000000_FFFF0000, 128'h13579BDF_2468ACE0_40000000_00010000},
    {1'b1, 2'b11, 128'h80000000_7FFFFFFF_FFFFFFFF_12345678, 128'h80000000_00000001_00000001_EDCBA988},
    {1'b0, 2'b11, 128'h0F0F0F0F_F0F0F0F0_C0000000_FFFF0000, 128'h13579BDF_2468ACE0_40000000_00010000},
    {1'b1, 2'b00, 128'h0102030405060708090A0B0C0D0E0F10, 128'hFFFEFDFCFBFAF9F8F7F6F5F4F3F2F1F0},
    {1'b1, 2'b01, 128'h0102030405060708090A0B0C0D0E0F10, 128'hFFFEFDFCFBFAF9F8F7F6F5F4F3F2F1F0}
  };

  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic [1:0] sel, input logic w);
    logic [127:0] r = '0;
    logic c = 1'b0;
    int lw  = (sel == 2'b00) ? 8 : (sel == 2'b01) ? 16 : 32;
    int top = w ? 128 : 64;
    for (int i = 0; i < top; i++) begin
      if (i % lw == 0) c = 1'b0;
      r[i] = a[i] ^ b[i] ^ c;
      c = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    applied++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic w, input logic [1:0] sel, input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    in_valid = 1'b1; wide = w; lane_sel = sel; opa = a; opb = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic string tag(input logic w, input logic [1:0] sel);
    string s = (sel == 2'b00) ? "R1" : (sel == 2'b01) ? "R2" : (sel == 2'b10) ? "R3" : "R4";
    return {s, w ? "/R7" : "/R6"};
  endfunction

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

  initial begin
    logic [127:0] held;
    #1;
    check("R9 reset valid", {127'd0, out_valid}, 128'd0);
    check("R9 reset sum", sum, 128'd0);
    #10 rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][258], VEC[v][257:256], VEC[v][255:128], VEC[v][127:0]);
      check(tag(VEC[v][258], VEC[v][257:256]), sum,
            model(VEC[v][255:128], VEC[v][127:0], VEC[v][257:256], VEC[v][258]));
      check("R8 valid", {127'd0, out_valid}, 128'd1);
    end

    // R5: all-ones operands put a carry at every lane edge
    apply(1'b1, 2'b00, '1, '1); check("R5 byte wide",  sum, {16{8'hFE}});
    apply(1'b1, 2'b01, '1, '1); check("R5 word wide",  sum, {8{16'hFFFE}});
    apply(1'b1, 2'b10, '1, '1); check("R5 dword wide", sum, {4{32'hFFFFFFFE}});
    apply(1'b1, 2'b11, '1, '1); check("R4 R5 dword alias", sum, {4{32'hFFFFFFFE}});
    apply(1'b0, 2'b00, '1, '1); check("R5 R6 byte narrow", sum, {64'd0, {8{8'hFE}}});
    apply(1'b0, 2'b10, '1, '1); check("R5 R6 dword narrow", sum, {64'd0, {2{32'hFFFFFFFE}}});
    apply(1'b1, 2'b00, '1, {16{8'h01}}); check("R5 byte wrap to zero", sum, 128'd0);
    apply(1'b1, 2'b01, '1, {8{16'h0001}}); check("R5 word wrap to zero", sum, 128'd0);
    apply(1'b1, 2'b10, '1, {4{32'h00000001}}); check("R5 dword wrap to zero", sum, 128'd0);

    // R8: idle cycle keeps result and drops valid
    apply(1'b1, 2'b00, {16{8'h7F}}, {16{8'h01}});
    held = sum;
    check("R1 signed wrap", held, {16{8'h80}});
    opa = '1; opb = '1; lane_sel = 2'b10; wide = 1'b1;
    @(negedge clk);
    check("R8 idle valid", {127'd0, out_valid}, 128'd0);
    check("R8 idle hold", sum, held);

    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end
endmodule